// File: doc/BRIEF.md
# Rotate-Zoom Pixel Blitter

This block draws scaled and rotated imagery one pixel at a time on behalf of a processor. Software first sets a start coordinate and a signed X and Y step through a four-entry register file. Both coordinates are fixed-point numbers with eight fractional bits. Software then reads from a blit window. Each read uses the integer part of the current coordinate to look up one 15-bit texel in a texture ROM. If the texel is not transparent, it is written into the back framebuffer, at the same word offset as the window read. After every read, the coordinates advance by the steps.

Sweeping the window while changing the steps row by row lets software trace any affine path through the texture. The block itself walks no rectangles. Each pixel costs one window read, and the read is held off until the texture lookup has returned. The data returned by a window read is always zero.

Top module: `rzblit_top`

## Requirements
- R1: Register 0 (`reg_sel`=0) holds the Y step in its low halfword as a 16-bit two's-complement value, merged per byte under `reg_be`.
- R2: A write to register 1 merges the data under `reg_be`. It then loads X integer = merged bits 8..0 and Y integer = merged bits 31..9, with both 8-bit fractions cleared. If a register 1 write and a coordinate step fall in the same cycle, the load wins.
- R3: Register 2 takes the X step (signed 16 bits) from the merged lower halfword when `reg_be[1:0]` has any bit set. Otherwise, when only `reg_be[3:2]` has a bit set, it takes the step from the merged upper halfword.
- R4: Writes to register 3 change neither the coordinates nor the steps.
- R5: The ROM address is (Xint + Yint·512) mod TEX_WORDS, where Xint is the 9-bit integer part of X.
- R6: A texel whose low 15 bits are zero, including one with only bit 15 set, causes no framebuffer write.
- R7: A non-zero texel (bit 15 cleared) is written at `fb_addr` = the window offset. `fb_hwe` is 2'b10 for an upper-half access and 2'b01 for a lower-half access. `fb_wdata` carries the pixel in both halfwords with bits 15 and 31 zero.
- R8: After every blit, X bits 15..0 become (X[15:0] + Xstep) mod 2^16 and X bit 16 is kept.
- R9: After every blit, Y bits 15..0 become (Y[15:0] + Ystep) mod 2^16 and Y bits 30..16 are kept.
- R10: `win_rdata` is zero whenever `win_ack` is high.
- R11: When idle, a raised `win_req` drives `rom_en` in that same cycle with `win_ack` low. `win_ack` rises in the next cycle, together with the write. A request held high continuously is served once every two cycles, and none is dropped.
- R12: After reset, `win_ack`, `rom_en` and `fb_we` are low, and the coordinates and steps are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte enables for register write |
| win_req | input | 1 | Blit window read request, held until acknowledged |
| win_addr | input | FB_AW | Word offset of the window read |
| win_upper | input | 1 | 1 when the read accesses the upper halfword |
| win_ack | output | 1 | Window read completes this cycle |
| win_rdata | output | 32 | Window read data, always zero |
| rom_en | output | 1 | Texture ROM read enable |
| rom_addr | output | TEX_AW | Texture ROM word address |
| rom_data | input | 16 | Texel, valid one clock after `rom_en` |
| fb_we | output | 1 | Back framebuffer write strobe |
| fb_addr | output | FB_AW | Framebuffer word address |
| fb_hwe | output | 2 | Halfword write enables, bit 1 = upper |
| fb_wdata | output | 32 | Framebuffer write data |

## Verification
The assertions assume four things about the inputs. A requester holds `win_req` high until it sees `win_ack`. The texture ROM returns data exactly one clock after `rom_en`. Window reads and register writes are sampled only on clock edges. The bench drives every request from a task that raises `win_req` and waits for the acknowledge. It models the ROM as a registered lookup, and it changes register-write inputs only between edges. Register-1 loads collide with a step only in the dedicated priority scenario.

// File: rtl/rzb_pkg.sv
package rzb_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } blit_state_t;

   // per-byte merge of a 16-bit halfword under two byte enables
   function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                           input logic [15:0] new_v,
                                           input logic [1:0]  be);
      logic [15:0] r;
      r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
      r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
      return r;
   endfunction

endpackage

// File: rtl/rzb_regs.sv
module rzb_regs
   import rzb_pkg::*;
#(
   parameter int DW     = 32,
   parameter int STEP_W = 16,
   parameter int XINT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [DW-1:0]     wdata,
   input  logic [DW/8-1:0]   be,
   output logic [STEP_W-1:0] dx,
   output logic [STEP_W-1:0] dy,
   output logic              load,
   output logic [XINT_W-1:0]    ld_xint,
   output logic [DW-XINT_W-1:0] ld_yint
);
   localparam int HALF = DW / 2;

   initial begin
      assert (DW == 32) else $error("rzb_regs: bus must be 32 bits");
      assert (STEP_W == HALF) else $error("rzb_regs: step must be a halfword");
   end

   logic [STEP_W-1:0] dy_q, dx_q;
   logic [DW-1:0]     r1_q, r1_nx, r2_q, r2_nx;
   logic              hit0, hit1, hit2, lo_hit, hi_hit;

   assign hit0   = we && (sel == 2'd0);
   assign hit1   = we && (sel == 2'd1);
   assign hit2   = we && (sel == 2'd2);
   assign lo_hit = |be[1:0];
   assign hi_hit = |be[3:2];

   assign r1_nx = {merge16(r1_q[DW-1:HALF], wdata[DW-1:HALF], be[3:2]),
                   merge16(r1_q[HALF-1:0],  wdata[HALF-1:0],  be[1:0])};
   assign r2_nx = {merge16(r2_q[DW-1:HALF], wdata[DW-1:HALF], be[3:2]),
                   merge16(r2_q[HALF-1:0],  wdata[HALF-1:0],  be[1:0])};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dy_q <= '0;
         dx_q <= '0;
         r1_q <= '0;
         r2_q <= '0;
      end else begin
         if (hit0) dy_q <= merge16(dy_q, wdata[HALF-1:0], be[1:0]);
         if (hit1) r1_q <= r1_nx;
         if (hit2) begin
            r2_q <= r2_nx;
            if (lo_hit)      dx_q <= r2_nx[HALF-1:0];
            else if (hi_hit) dx_q <= r2_nx[DW-1:HALF];
         end
      end
   end

   assign dx      = dx_q;
   assign dy      = dy_q;
   assign load    = hit1;
   assign ld_xint = r1_nx[XINT_W-1:0];
   assign ld_yint = r1_nx[DW-1:XINT_W];

   // R3: the X step only moves on a register 2 write
   a_r3_dx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit2 |=> $stable(dx_q));
   // R1: the Y step only moves on a register 0 write
   a_r1_dy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit0 |=> $stable(dy_q));

endmodule

// File: rtl/rzb_axis.sv
module rzb_axis #(
   parameter int INT_W  = 9,
   parameter int FRAC_W = 8,
   parameter int STEP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [INT_W-1:0]  ld_int,
   input  logic              step_en,
   input  logic [STEP_W-1:0] step,
   output logic [INT_W-1:0]  int_o
);
   localparam int W = INT_W + FRAC_W;

   initial assert (INT_W > 0 && FRAC_W > 0) else $error("rzb_axis: bad widths");

   logic [W-1:0] pos_q, pos_nx;

   generate
      if (W > STEP_W) begin : g_keep_hi
         assign pos_nx = {pos_q[W-1:STEP_W], pos_q[STEP_W-1:0] + step};
         // R8 on the X axis, R9 on the Y axis: bits above the step width survive
         a_r8_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && !load) |=> (pos_q[W-1:STEP_W] == $past(pos_q[W-1:STEP_W])));
      end else begin : g_full_wrap
         assign pos_nx = pos_q + step[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       pos_q <= '0;
      else if (load)    pos_q <= {ld_int, {FRAC_W{1'b0}}};
      else if (step_en) pos_q <= pos_nx;
   end

   assign int_o = pos_q[W-1:FRAC_W];

   // R2: a load always leaves a zero fraction, even against a step
   a_r2_frac_clear: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pos_q[FRAC_W-1:0] == '0));

endmodule

// File: rtl/rzb_texaddr.sv
module rzb_texaddr #(
   parameter int XINT_W    = 9,
   parameter int YINT_W    = 23,
   parameter int TEX_WORDS = 3 * (2 ** 20),
   parameter int TEX_AW    = $clog2(TEX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XINT_W-1:0] xint,
   input  logic [YINT_W-1:0] yint,
   output logic [TEX_AW-1:0] rom_addr
);
   localparam int RAW_W = XINT_W + YINT_W;
   localparam bit POW2  = (TEX_WORDS & (TEX_WORDS - 1)) == 0;

   initial assert (TEX_AW <= RAW_W && TEX_WORDS > 1) else $error("rzb_texaddr: bad size");

   logic [RAW_W-1:0] raw;
   assign raw = {yint, xint};   // xint + yint * 2^XINT_W

   generate
      if (POW2) begin : g_mask
         assign rom_addr = raw[TEX_AW-1:0];
      end else begin : g_mod
         assign rom_addr = TEX_AW'(raw % RAW_W'(TEX_WORDS));
      end
   endgenerate

   // R5: the fetch address never leaves the texture
   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, rom_addr} < (TEX_AW + 1)'(TEX_WORDS));

endmodule

// File: rtl/rzb_seq.sv
module rzb_seq
   import rzb_pkg::*;
#(
   parameter int FB_AW = 17,
   parameter int TEX_W = 16,
   parameter int PIX_W = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               win_req,
   input  logic [FB_AW-1:0]   win_addr,
   input  logic               win_upper,
   input  logic [TEX_W-1:0]   rom_data,
   output logic               rom_en,
   output logic               step_en,
   output logic               win_ack,
   output logic               fb_we,
   output logic [FB_AW-1:0]   fb_addr,
   output logic [1:0]         fb_hwe,
   output logic [2*TEX_W-1:0] fb_wdata
);
   localparam logic [TEX_W-1:0] PIX_MASK = TEX_W'((1 << PIX_W) - 1);

   initial assert (PIX_W < TEX_W) else $error("rzb_seq: pixel must be narrower than texel");

   blit_state_t       st_q;
   logic [FB_AW-1:0]  addr_q;
   logic              up_q;
   logic [TEX_W-1:0]  texel;
   logic              busy;

   assign busy   = (st_q == ST_WAIT);
   assign rom_en = !busy && win_req;
   assign texel  = rom_data & PIX_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         up_q   <= 1'b0;
      end else if (busy) begin
         st_q <= ST_IDLE;
      end else if (win_req) begin
         st_q   <= ST_WAIT;
         addr_q <= win_addr;
         up_q   <= win_upper;
      end
   end

   assign win_ack  = busy;
   assign step_en  = busy;
   assign fb_we    = busy && (texel != '0);
   assign fb_addr  = addr_q;
   assign fb_hwe   = up_q ? 2'b10 : 2'b01;
   assign fb_wdata = {texel, texel};

   // R11: the acknowledge arrives exactly one clock after the fetch
   a_r11_ack_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      rom_en |=> win_ack);
   // R11: no two acknowledges in a row
   a_r11_ack_gap: assert property (@(posedge clk) disable iff (!rst_n)
      win_ack |=> !win_ack);
   // R7: the write lands at the offset the request presented
   a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      win_ack |-> (fb_addr == $past(win_addr)));
   // R7: exactly one halfword is enabled per write
   a_r7_one_half: assert property (@(posedge clk) disable iff (!rst_n)
      fb_we |-> ($countones(fb_hwe) == 1));
   // R6: a written pixel is never transparent and never has bit 15
   a_r6_opaque: assert property (@(posedge clk) disable iff (!rst_n)
      fb_we |-> ((fb_wdata[PIX_W-1:0] != '0) && !fb_wdata[TEX_W-1]));

endmodule

// File: rtl/rzblit_top.sv
module rzblit_top #(
   parameter int FB_AW     = 17,
   parameter int TEX_WORDS = 3 * (2 ** 20),
   parameter int XINT_W    = 9,
   parameter int FRAC_W    = 8,
   parameter int STEP_W    = 16,
   parameter int DW        = 32,
   parameter int TEX_W     = 16,
   parameter int PIX_W     = 15,
   parameter int TEX_AW    = $clog2(TEX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [DW-1:0]     reg_wdata,
   input  logic [DW/8-1:0]   reg_be,
   input  logic              win_req,
   input  logic [FB_AW-1:0]  win_addr,
   input  logic              win_upper,
   output logic              win_ack,
   output logic [DW-1:0]     win_rdata,
   output logic              rom_en,
   output logic [TEX_AW-1:0] rom_addr,
   input  logic [TEX_W-1:0]  rom_data,
   output logic              fb_we,
   output logic [FB_AW-1:0]  fb_addr,
   output logic [1:0]        fb_hwe,
   output logic [DW-1:0]     fb_wdata
);
   localparam int YINT_W = DW - XINT_W;

   initial begin
      assert (DW == 2 * TEX_W) else $error("rzblit_top: bus must hold two texels");
      assert (TEX_AW == $clog2(TEX_WORDS)) else $error("rzblit_top: TEX_AW mismatch");
   end

   logic [STEP_W-1:0] dx, dy;
   logic              load, step_en;
   logic [XINT_W-1:0] ld_xint, xint;
   logic [YINT_W-1:0] ld_yint, yint;

   rzb_regs #(.DW(DW), .STEP_W(STEP_W), .XINT_W(XINT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
      .be(reg_be), .dx(dx), .dy(dy), .load(load), .ld_xint(ld_xint), .ld_yint(ld_yint));

   rzb_axis #(.INT_W(XINT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_xaxis (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_int(ld_xint),
      .step_en(step_en), .step(dx), .int_o(xint));

   rzb_axis #(.INT_W(YINT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_yaxis (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_int(ld_yint),
      .step_en(step_en), .step(dy), .int_o(yint));

   rzb_texaddr #(.XINT_W(XINT_W), .YINT_W(YINT_W), .TEX_WORDS(TEX_WORDS),
                 .TEX_AW(TEX_AW)) u_taddr (
      .clk(clk), .rst_n(rst_n), .xint(xint), .yint(yint), .rom_addr(rom_addr));

   rzb_seq #(.FB_AW(FB_AW), .TEX_W(TEX_W), .PIX_W(PIX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .win_req(win_req), .win_addr(win_addr),
      .win_upper(win_upper), .rom_data(rom_data), .rom_en(rom_en),
      .step_en(step_en), .win_ack(win_ack), .fb_we(fb_we), .fb_addr(fb_addr),
      .fb_hwe(fb_hwe), .fb_wdata(fb_wdata));

   assign win_rdata = '0;

   // R11: the fetch address is stable from request to acknowledge
   a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_en && !load) |=> $stable(rom_addr));

endmodule

// File: tb/rzblit_top_bench.sv
`timescale 1ns/1ps
module rzblit_top_bench;
   localparam int FB_AW = 17;
   localparam int TW    = 1536;
   localparam int TAW   = $clog2(TW);

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 0; logic [1:0] reg_sel = 0; logic [31:0] reg_wdata = 0; logic [3:0] reg_be = 0;
   logic win_req = 0; logic [FB_AW-1:0] win_addr = 0; logic win_upper = 0;
   logic win_ack, rom_en, fb_we; logic [31:0] win_rdata, fb_wdata;
   logic [TAW-1:0] rom_addr; logic [15:0] rom_data = 0;
   logic [FB_AW-1:0] fb_addr; logic [1:0] fb_hwe;

   int total = 0, bad = 0;
   bit done = 0;

   // model state
   logic [16:0] mx = 0; logic [30:0] my = 0;
   logic [15:0] mdx = 0, mdy = 0;
   logic [31:0] mr1 = 0, mr2 = 0;

   always #2 clk = ~clk;

   rzblit_top #(.FB_AW(FB_AW), .TEX_WORDS(TW)) u_rzblit_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_be(reg_be), .win_req(win_req), .win_addr(win_addr), .win_upper(win_upper),
      .win_ack(win_ack), .win_rdata(win_rdata), .rom_en(rom_en), .rom_addr(rom_addr),
      .rom_data(rom_data), .fb_we(fb_we), .fb_addr(fb_addr), .fb_hwe(fb_hwe),
      .fb_wdata(fb_wdata));

   function automatic logic [15:0] rom_fn(input int a);
      logic [15:0] v;
      if (a % 5 == 0) return 16'h8000;
      v = 16'(a * 40503 + 257);
      if (v[14:0] == 0) v = 16'h0001;
      return v;
   endfunction

   always_ff @(posedge clk) if (rom_en) rom_data <= rom_fn(int'(rom_addr));

   function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
      return r;
   endfunction

   function automatic int exp_addr();
      logic [31:0] raw;
      raw = {my[30:8], mx[16:8]};
      return int'(longint'(raw) % TW);
   endfunction

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
      end
   endtask

   task automatic do_load(input logic [31:0] d, input logic [3:0] be);
      mr1 = mrg(mr1, d, be);
      mx = {mr1[8:0], 8'h00};
      my = {mr1[31:9], 8'h00};
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d, input logic [3:0] be);
      reg_we = 1; reg_sel = s; reg_wdata = d; reg_be = be;
      @(posedge clk); #1;
      reg_we = 0; reg_be = 0;
      case (s)
         2'd0: mdy = mrg({16'h0, mdy}, d, be) & 32'hFFFF;
         2'd1: do_load(d, be);
         2'd2: begin
            mr2 = mrg(mr2, d, be);
            if (|be[1:0]) mdx = mr2[15:0];
            else if (|be[3:2]) mdx = mr2[31:16];
         end
         default: ;
      endcase
   endtask

   // one blit; keep leaves win_req high for a back-to-back read;
   // ld requests a register 1 write in the acknowledge cycle
   task automatic blit(input logic [FB_AW-1:0] a, input bit up, input bit keep,
                       input bit ld, input logic [31:0] ldd, input string tag);
      int ea; logic [14:0] pix;
      win_req = 1; win_addr = a; win_upper = up;
      #1;
      ea = exp_addr();
      chk(win_ack == 0, {tag, " R11 no ack while fetching"}, win_ack, 0);
      chk(rom_en == 1, {tag, " R11 fetch issued"}, rom_en, 1);
      chk(int'(rom_addr) == ea, {tag, " R5 texel address"}, rom_addr, ea);
      @(posedge clk); #1;
      pix = rom_fn(ea) & 16'h7FFF;
      chk(win_ack == 1, {tag, " R11 ack"}, win_ack, 1);
      chk(win_rdata == 0, {tag, " R10 read data"}, win_rdata, 0);
      if (pix == 0) chk(fb_we == 0, {tag, " R6 transparent"}, fb_we, 0);
      else begin
         chk(fb_we == 1 && fb_addr == a, {tag, " R7 write addr"}, {fb_we, fb_addr}, {1'b1, a});
         chk(fb_hwe == (up ? 2'b10 : 2'b01), {tag, " R7 half enable"}, fb_hwe, up ? 2 : 1);
         chk(fb_wdata == {1'b0, pix, 1'b0, pix}, {tag, " R7 write data"}, fb_wdata, {1'b0, pix, 1'b0, pix});
      end
      if (ld) begin
         reg_we = 1; reg_sel = 2'd1; reg_wdata = ldd; reg_be = 4'hF;
         do_load(ldd, 4'hF);
      end else begin
         mx = {mx[16], mx[15:0] + mdx};   // R8
         my = {my[30:16], my[15:0] + mdy}; // R9
      end
      if (!keep) win_req = 0;
      @(posedge clk); #1;
      reg_we = 0; reg_be = 0;
   endtask

   task automatic t_reset();
      chk(win_ack == 0 && rom_en == 0 && fb_we == 0, "R12 idle outputs after reset",
          {win_ack, rom_en, fb_we}, 0);
      blit(17'h00010, 0, 0, 0, 0, "R12 first blit at zero coords");
      blit(17'h00011, 1, 0, 0, 0, "R12 zero steps keep coords");
   endtask

   task automatic t_steps();
      wr(2'd1, {23'd3, 9'd7}, 4'hF);
      wr(2'd2, 32'h0000_0180, 4'h3);          // X step +1.5
      wr(2'd0, 32'h0000_0040, 4'h3);          // Y step +0.25 (R1)
      for (int i = 0; i < 6; i++) blit(17'(i), i[0], 0, 0, 0, "R8 R9 positive steps");
   endtask

   task automatic t_neg_wrap();
      wr(2'd1, {23'h10001, 9'd2}, 4'hF);      // Y int 0x10001: low byte small
      wr(2'd0, 32'h1234_FF00, 4'h3);          // Y step -1, upper half of word ignored (R1)
      wr(2'd2, 32'h0000_0000, 4'h3);
      for (int i = 0; i < 4; i++) blit(17'h100 + 17'(i), 0, 0, 0, 0, "R9 negative step wraps");
   endtask

   task automatic t_x_wrap();
      wr(2'd0, 32'h0, 4'h3);
      wr(2'd1, {23'd1, 9'h1F0}, 4'hF);        // X bit 16 set
      wr(2'd2, 32'h0000_0400, 4'h3);          // +4
      for (int i = 0; i < 6; i++) blit(17'h200 + 17'(i), 1, 0, 0, 0, "R8 X wrap keeps bit 16");
   endtask

   task automatic t_dx_halves();
      wr(2'd1, {23'd2, 9'd100}, 4'hF);
      wr(2'd2, 32'hFE00_0300, 4'hC);          // upper only: -2
      blit(17'h300, 0, 0, 0, 0, "R3 upper half");
      blit(17'h301, 0, 0, 0, 0, "R3 upper half step");
      wr(2'd2, 32'hAAAA_0300, 4'h3);          // lower only: +3
      blit(17'h302, 0, 0, 0, 0, "R3 lower half");
      blit(17'h303, 0, 0, 0, 0, "R3 lower half step");
      wr(2'd2, 32'hFF00_0100, 4'hF);          // both: lower wins, +1
      blit(17'h304, 0, 0, 0, 0, "R3 both halves");
      blit(17'h305, 0, 0, 0, 0, "R3 both halves step");
   endtask

   task automatic t_reg3();
      wr(2'd3, 32'hFFFF_FFFF, 4'hF);
      blit(17'h400, 1, 0, 0, 0, "R4 reg3 inert");
      blit(17'h401, 1, 0, 0, 0, "R4 reg3 inert step");
   endtask

   task automatic t_transparent();
      wr(2'd1, 32'h0, 4'hF);
      wr(2'd2, 32'h0000_0500, 4'h3);          // +5 pixels: addr stays multiple of 5
      wr(2'd0, 32'h0, 4'h3);
      for (int i = 0; i < 3; i++) blit(17'h500 + 17'(i), 0, 0, 0, 0, "R6 zero and 0x8000 texels");
   endtask

   task automatic t_backtoback();
      wr(2'd1, {23'd9, 9'd33}, 4'hF);
      wr(2'd2, 32'h0000_0100, 4'h3);
      for (int i = 0; i < 5; i++) blit(17'h600 + 17'(i), i[1], (i != 4), 0, 0, "R11 back to back");
   endtask

   task automatic t_load_priority();
      wr(2'd0, 32'h0000_0300, 4'h3);
      wr(2'd2, 32'h0000_0700, 4'h3);
      blit(17'h700, 0, 0, 1, {23'd40, 9'd11}, "R2 load beside step");
      blit(17'h701, 0, 0, 0, 0, "R2 load wins over step");
      blit(17'h702, 0, 0, 0, 0, "R2 stepping resumes");
   endtask

   task automatic t_modulo();
      wr(2'd0, 32'h0000_0100, 4'h3);
      wr(2'd2, 32'h0000_0100, 4'h3);
      wr(2'd1, {16'hABCD, 7'h55, 9'h1FF}, 4'h3); // partial merge of low half (R2)
      blit(17'h1FFFF, 1, 0, 0, 0, "R5 modulo large Y");
      wr(2'd1, {23'h7FFFFF, 9'h1FE}, 4'hF);
      for (int i = 0; i < 3; i++) blit(17'h800 + 17'(i), 0, 0, 0, 0, "R5 modulo top of range");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_steps();
      t_neg_wrap();
      t_x_wrap();
      t_dx_halves();
      t_reg3();
      t_transparent();
      t_backtoback();
      t_load_priority();
      t_modulo();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule